// File: doc/BRIEF.md
# Decoded Micro-Op Cache

This block sits beside an instruction decoder and keeps a copy of every decoded result, indexed by the fetch address it came from. Each incoming fetch address is looked up here first. On a hit, the stored micro-ops go straight to the back end. In the same cycle the block drops its decode-enable output, so the fetch and decode stage may idle. On a miss, the address is handed to the decode path. Whatever that path later emits comes back on the fill port and is written in with no filtering.

The array is direct mapped with one tag per line. Each line keeps up to `LANES` micro-ops for a single fetch address; a line never follows a taken branch. To stay inclusive in the L1 instruction cache, an L1 line eviction arrives on the invalidate port and clears every entry whose address lies in that L1 line.

The request, result, miss and fill paths follow valid/ready rules. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. A result stays presented, unchanged, until its consumer takes it (`out_ready` for a hit, `miss_ready` for a miss). While a result is held, `req_ready` stays low. The fill port never stalls: `fill_ready` is always high. The invalidate port is plain.

Top module: `uop_cache`

## Requirements
- R1: After reset every line is invalid, `out_valid` and `miss_valid` are low, `dec_en` and `req_ready` are high, and a lookup of any address misses.
- R2: A request accepted at a clock edge produces exactly one result on the next cycle. A hit raises `out_valid` with the line's micro-ops and count. A miss raises `miss_valid` with `miss_addr` equal to the requested address.
- R3: Every `fill_valid` cycle writes the line selected by `fill_addr`, storing tag, micro-ops and count unconditionally. `fill_ready` is always 1.
- R4: Set index is `addr[IDX_W-1:0]` and the tag is the remaining upper bits. A fill to an occupied set replaces the old line, so the old address then misses.
- R5: `dec_en` is 0 exactly while a hit result is presented, and 1 otherwise.
- R6: A lookup accepted in the same cycle as a fill to the same set is reported as a miss. The fill still takes effect.
- R7: `inv_valid` with `inv_line` (fetch address bits `[ADDR_W-1:L1_OFF_W]`) clears every line whose address has those upper bits. A lookup accepted in the same cycle that falls in that L1 line misses.
- R8: While `out_valid && !out_ready`, or `miss_valid && !miss_ready`, the result stays stable and `req_ready` is 0.
- R9: In `out_uops`, lane k occupies bits `[k*UOP_W +: UOP_W]`. Lanes with k >= `out_count` read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch address offered |
| req_ready | output | 1 | Lookup can accept an address |
| req_addr | input | ADDR_W | Fetch address |
| out_valid | output | 1 | Hit result presented |
| out_ready | input | 1 | Back end takes hit result |
| out_uops | output | LANES*UOP_W | Micro-ops, lane 0 in low bits |
| out_count | output | CNT_W | Number of valid lanes |
| miss_valid | output | 1 | Miss handed to decode path |
| miss_ready | input | 1 | Decode path takes the miss |
| miss_addr | output | ADDR_W | Address that missed |
| fill_valid | input | 1 | Decoded line to store |
| fill_ready | output | 1 | Always 1 |
| fill_addr | input | ADDR_W | Fetch address of decoded line |
| fill_uops | input | LANES*UOP_W | Decoded micro-ops |
| fill_count | input | CNT_W | Number of decoded micro-ops |
| inv_valid | input | 1 | L1 instruction line evicted |
| inv_line | input | ADDR_W-L1_OFF_W | Evicted L1 line address |
| dec_en | output | 1 | Decode path enable, low on a hit |

## Verification
A lookup result is due one clock edge after its request transfers, with `dec_en` tracking it in the same cycle. Fills and invalidations take effect at the edge that samples them, so a lookup one cycle later already sees them. The bench drives on the falling edge and samples on the falling edge right after the accepting rising edge. It then leaves the ready inputs high so that the result retires on the next edge. For stall checks it holds the ready inputs low over several falling edges and samples at each one.

// File: rtl/uopc_pkg.sv
package uopc_pkg;
  typedef enum logic [1:0] {
    RES_IDLE = 2'd0,
    RES_HIT  = 2'd1,
    RES_MISS = 2'd2
  } res_kind_e;
endpackage

// File: rtl/uopc_array.sv
module uopc_array #(
  parameter int SETS     = 16,
  parameter int TAG_W    = 12,
  parameter int UOP_W    = 16,
  parameter int LANES    = 4,
  parameter int CNT_W    = 3,
  parameter int L1_OFF_W = 2,
  parameter int ADDR_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(SETS)-1:0]  rd_idx,
  output logic                     rd_valid,
  output logic [TAG_W-1:0]         rd_tag,
  output logic [LANES*UOP_W-1:0]   rd_data,
  output logic [CNT_W-1:0]         rd_cnt,
  input  logic                     wr_en,
  input  logic [$clog2(SETS)-1:0]  wr_idx,
  input  logic [TAG_W-1:0]         wr_tag,
  input  logic [LANES*UOP_W-1:0]   wr_data,
  input  logic [CNT_W-1:0]         wr_cnt,
  input  logic                     inv_en,
  input  logic [ADDR_W-L1_OFF_W-1:0] inv_line
);
  localparam int IDX_W = $clog2(SETS);
  localparam int HI_W  = IDX_W - L1_OFF_W;

  logic [SETS-1:0]          valid_q;
  logic [TAG_W-1:0]         tag_q  [SETS];
  logic [LANES*UOP_W-1:0]   data_q [SETS];
  logic [CNT_W-1:0]         cnt_q  [SETS];
  logic [SETS-1:0]          inv_hit;

  // Each set compares the L1 line address against the tag it holds after
  // this edge's fill, so a fill and an eviction in one cycle stay inclusive.
  for (genvar s = 0; s < SETS; s++) begin : g_inv
    localparam logic [IDX_W-1:0] SIDX = IDX_W'(s);
    logic [TAG_W-1:0] eff_tag;
    assign eff_tag    = (wr_en && wr_idx == SIDX) ? wr_tag : tag_q[s];
    assign inv_hit[s] = inv_en && ({eff_tag, SIDX[IDX_W-1:L1_OFF_W]} == inv_line);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (wr_en && wr_idx == IDX_W'(s)) valid_q[s] <= 1'b1;
        if (inv_hit[s])                   valid_q[s] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
      cnt_q[wr_idx]  <= wr_cnt;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];
  assign rd_cnt   = cnt_q[rd_idx];

  // R3
  fill_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !inv_hit[wr_idx] |=> valid_q[$past(wr_idx)]);
  // R7
  inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en && inv_hit[rd_idx] |=> !valid_q[$past(rd_idx)]);
  localparam int UNUSED_HI = HI_W;
endmodule

// File: rtl/uopc_lookup.sv
module uopc_lookup #(
  parameter int ADDR_W   = 16,
  parameter int IDX_W    = 4,
  parameter int UOP_W    = 16,
  parameter int LANES    = 4,
  parameter int CNT_W    = 3,
  parameter int L1_OFF_W = 2
) (
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic                       rd_valid,
  input  logic [ADDR_W-IDX_W-1:0]    rd_tag,
  input  logic [LANES*UOP_W-1:0]     rd_data,
  input  logic [CNT_W-1:0]           rd_cnt,
  input  logic                       fill_en,
  input  logic [IDX_W-1:0]           fill_idx,
  input  logic                       inv_en,
  input  logic [ADDR_W-L1_OFF_W-1:0] inv_line,
  output logic                       hit,
  output logic [LANES*UOP_W-1:0]     uops
);
  logic tag_eq, fill_clash, inv_clash;

  assign tag_eq     = rd_valid && (rd_tag == req_addr[ADDR_W-1:IDX_W]);
  assign fill_clash = fill_en && (fill_idx == req_addr[IDX_W-1:0]);
  assign inv_clash  = inv_en && (inv_line == req_addr[ADDR_W-1:L1_OFF_W]);
  assign hit        = tag_eq && !fill_clash && !inv_clash;

  // Lanes past the stored count are driven to zero.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign uops[l*UOP_W +: UOP_W] =
      (CNT_W'(l) < rd_cnt) ? rd_data[l*UOP_W +: UOP_W] : '0;
  end
endmodule

// File: rtl/uopc_result.sv
module uopc_result
  import uopc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              lk_hit,
  input  logic [DATA_W-1:0] lk_uops,
  input  logic [CNT_W-1:0]  lk_cnt,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_uops,
  output logic [CNT_W-1:0]  out_count,
  output logic              miss_valid,
  input  logic              miss_ready,
  output logic [ADDR_W-1:0] miss_addr,
  output logic              dec_en
);
  res_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] uops_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              retire, accept;

  assign retire    = (kind_q == RES_HIT && out_ready) || (kind_q == RES_MISS && miss_ready);
  assign req_ready = (kind_q == RES_IDLE) || retire;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= RES_IDLE;
    end else if (accept) begin
      kind_q <= lk_hit ? RES_HIT : RES_MISS;
    end else if (retire) begin
      kind_q <= RES_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q <= req_addr;
      uops_q <= lk_hit ? lk_uops : '0;
      cnt_q  <= lk_hit ? lk_cnt : '0;
    end
  end

  assign out_valid  = (kind_q == RES_HIT);
  assign miss_valid = (kind_q == RES_MISS);
  assign out_uops   = uops_q;
  assign out_count  = cnt_q;
  assign miss_addr  = addr_q;
  assign dec_en     = (kind_q != RES_HIT);

  // R2
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_valid ^ miss_valid));
  // R8
  hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_uops) && $stable(out_count));
  // R8
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && !miss_ready |=> miss_valid && $stable(miss_addr));
  // R5
  gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !dec_en);
endmodule

// File: rtl/uop_cache.sv
module uop_cache #(
  parameter int ADDR_W   = 16,
  parameter int SETS     = 16,
  parameter int UOP_W    = 16,
  parameter int LANES    = 4,
  parameter int L1_OFF_W = 2,
  parameter int CNT_W    = $clog2(LANES + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ADDR_W-1:0]          req_addr,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [LANES*UOP_W-1:0]     out_uops,
  output logic [CNT_W-1:0]           out_count,
  output logic                       miss_valid,
  input  logic                       miss_ready,
  output logic [ADDR_W-1:0]          miss_addr,
  input  logic                       fill_valid,
  output logic                       fill_ready,
  input  logic [ADDR_W-1:0]          fill_addr,
  input  logic [LANES*UOP_W-1:0]     fill_uops,
  input  logic [CNT_W-1:0]           fill_count,
  input  logic                       inv_valid,
  input  logic [ADDR_W-L1_OFF_W-1:0] inv_line,
  output logic                       dec_en
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int DATA_W = LANES * UOP_W;

  logic              rd_valid, lk_hit;
  logic [TAG_W-1:0]  rd_tag;
  logic [DATA_W-1:0] rd_data, lk_uops;
  logic [CNT_W-1:0]  rd_cnt;

  assign fill_ready = 1'b1;

  uopc_array #(
    .SETS(SETS), .TAG_W(TAG_W), .UOP_W(UOP_W), .LANES(LANES),
    .CNT_W(CNT_W), .L1_OFF_W(L1_OFF_W), .ADDR_W(ADDR_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(req_addr[IDX_W-1:0]),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data), .rd_cnt(rd_cnt),
    .wr_en(fill_valid), .wr_idx(fill_addr[IDX_W-1:0]),
    .wr_tag(fill_addr[ADDR_W-1:IDX_W]), .wr_data(fill_uops), .wr_cnt(fill_count),
    .inv_en(inv_valid), .inv_line(inv_line)
  );

  uopc_lookup #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .UOP_W(UOP_W), .LANES(LANES),
    .CNT_W(CNT_W), .L1_OFF_W(L1_OFF_W)
  ) u_lookup (
    .req_addr(req_addr), .rd_valid(rd_valid), .rd_tag(rd_tag),
    .rd_data(rd_data), .rd_cnt(rd_cnt),
    .fill_en(fill_valid), .fill_idx(fill_addr[IDX_W-1:0]),
    .inv_en(inv_valid), .inv_line(inv_line),
    .hit(lk_hit), .uops(lk_uops)
  );

  uopc_result #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_result (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .lk_hit(lk_hit), .lk_uops(lk_uops), .lk_cnt(rd_cnt),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_uops(out_uops), .out_count(out_count),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
    .dec_en(dec_en)
  );

  // R6
  fill_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && fill_valid &&
    fill_addr[IDX_W-1:0] == req_addr[IDX_W-1:0] |=> miss_valid);
  // R8
  stall_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) || (miss_valid && !miss_ready) |-> !req_ready);
endmodule

// File: tb/uop_cache_tb.sv
module uop_cache_tb;
  localparam int AW = 16, LN = 4, UW = 16, CW = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, out_ready = 1, miss_ready = 1, fill_valid = 0, inv_valid = 0;
  logic [AW-1:0] req_addr = '0, fill_addr = '0;
  logic [LN*UW-1:0] fill_uops = '0;
  logic [CW-1:0] fill_count = '0;
  logic [AW-3:0] inv_line = '0;
  logic req_ready, out_valid, miss_valid, fill_ready, dec_en;
  logic [LN*UW-1:0] out_uops;
  logic [CW-1:0] out_count;
  logic [AW-1:0] miss_addr;

  always #2 clk = ~clk;

  uop_cache u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_uops(out_uops), .out_count(out_count), .miss_valid(miss_valid),
    .miss_ready(miss_ready), .miss_addr(miss_addr), .fill_valid(fill_valid),
    .fill_ready(fill_ready), .fill_addr(fill_addr), .fill_uops(fill_uops),
    .fill_count(fill_count), .inv_valid(inv_valid), .inv_line(inv_line),
    .dec_en(dec_en)
  );

  int total = 0, bad = 0;
  logic done = 0;

  // Reference model of the tag/valid/data array.
  logic          rv    [16];
  logic [AW-1:0] raddr [16];
  logic [2:0]    rcnt  [16];
  logic [15:0]   rbase [16];

  function automatic logic [63:0] make_uops(input logic [15:0] base, input logic [2:0] cnt, input bit masked);
    logic [63:0] v = '0;
    for (int k = 0; k < 4; k++)
      if (!masked || k < cnt) v[k*16 +: 16] = base + 16'(k);
    return v;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_fill(input logic [AW-1:0] a, input logic [2:0] c, input logic [15:0] b);
    @(negedge clk);
    fill_valid = 1; fill_addr = a; fill_count = c; fill_uops = make_uops(b, c, 0);
    @(posedge clk); #1 fill_valid = 0;
    rv[a[3:0]] = 1; raddr[a[3:0]] = a; rcnt[a[3:0]] = c; rbase[a[3:0]] = b;
  endtask

  task automatic do_inv(input logic [AW-3:0] line);
    @(negedge clk);
    inv_valid = 1; inv_line = line;
    @(posedge clk); #1 inv_valid = 0;
    for (int s = 0; s < 16; s++) if (rv[s] && raddr[s][15:2] == line) rv[s] = 0;
  endtask

  // R2 R4 R5 R9: lookup and compare with the reference model.
  task automatic do_look(input logic [AW-1:0] a);
    logic h; logic [3:0] i;
    i = a[3:0];
    h = rv[i] && raddr[i] == a;
    @(negedge clk);
    req_valid = 1; req_addr = a; out_ready = 1; miss_ready = 1;
    @(posedge clk); #1 req_valid = 0;
    @(negedge clk);
    check("R2 hit", {63'd0, out_valid}, {63'd0, h});
    check("R2 miss", {63'd0, miss_valid}, {63'd0, !h});
    check("R5 dec_en", {63'd0, dec_en}, {63'd0, !h});
    if (h) begin
      check("R9 uops", out_uops, make_uops(rbase[i], rcnt[i], 1));
      check("R2 count", {61'd0, out_count}, {61'd0, rcnt[i]});
    end else begin
      check("R2 miss_addr", {48'd0, miss_addr}, {48'd0, a});
    end
  endtask

  // op(4) addr/line(16) count(4) base(16); op 1 fill, 2 lookup, 3 invalidate
  localparam int NV = 13;
  localparam logic [39:0] VEC [NV] = '{
    40'h2_1234_0_0000, 40'h1_1234_4_0100, 40'h2_1234_0_0000,
    40'h1_5674_2_0200, 40'h2_1234_0_0000, 40'h2_5674_0_0000,
    40'h1_0005_1_0300, 40'h1_0006_3_0400, 40'h3_0001_0_0000,
    40'h2_0005_0_0000, 40'h2_0006_0_0000, 40'h1_1234_4_0500,
    40'h2_1234_0_0000
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 16; s++) rv[s] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 out_valid", {63'd0, out_valid}, 64'd0);
    check("R1 miss_valid", {63'd0, miss_valid}, 64'd0);
    check("R1 dec_en", {63'd0, dec_en}, 64'd1);
    check("R1 req_ready", {63'd0, req_ready}, 64'd1);
    check("R3 fill_ready", {63'd0, fill_ready}, 64'd1);
    do_look(16'h0000); // R1 empty cache misses

    for (int v = 0; v < NV; v++) begin
      case (VEC[v][39:36])
        4'h1: do_fill(VEC[v][35:20], VEC[v][18:16], VEC[v][15:0]); // R3 R4
        4'h2: do_look(VEC[v][35:20]);
        default: do_inv(VEC[v][33:20]); // R7
      endcase
    end

    // R6: fill to same set in the lookup's cycle forces a miss.
    do_fill(16'h00A9, 3'd2, 16'h0600);
    @(negedge clk);
    req_valid = 1; req_addr = 16'h00A9;
    fill_valid = 1; fill_addr = 16'h10A9; fill_count = 3'd1; fill_uops = make_uops(16'h0700, 3'd1, 0);
    @(posedge clk); #1 req_valid = 0; fill_valid = 0;
    rv[9] = 1; raddr[9] = 16'h10A9; rcnt[9] = 3'd1; rbase[9] = 16'h0700;
    @(negedge clk);
    check("R6 forced miss", {63'd0, miss_valid}, 64'd1);
    do_look(16'h10A9); // R6 fill took effect

    // R7: invalidate in the lookup's cycle forces a miss.
    do_fill(16'h0031, 3'd3, 16'h0800);
    @(negedge clk);
    req_valid = 1; req_addr = 16'h0031; inv_valid = 1; inv_line = 14'h000C;
    @(posedge clk); #1 req_valid = 0; inv_valid = 0;
    rv[1] = 0;
    @(negedge clk);
    check("R7 same-cycle miss", {63'd0, miss_valid}, 64'd1);
    do_look(16'h0031);

    // R8: stalled hit holds and blocks requests.
    do_fill(16'h0042, 3'd4, 16'h0900);
    @(negedge clk);
    out_ready = 0; req_valid = 1; req_addr = 16'h0042;
    @(posedge clk); #1 req_addr = 16'h0000;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 held valid", {63'd0, out_valid}, 64'd1);
      check("R8 held uops", out_uops, make_uops(16'h0900, 3'd4, 1));
      check("R8 req_ready low", {63'd0, req_ready}, 64'd0);
      check("R5 gated", {63'd0, dec_en}, 64'd0);
    end
    req_valid = 0; out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    check("R8 released", {63'd0, out_valid}, 64'd0);

    // Stalled miss.
    @(negedge clk);
    miss_ready = 0; req_valid = 1; req_addr = 16'hBEEF;
    @(posedge clk); #1 req_valid = 0;
    repeat (2) begin
      @(negedge clk);
      check("R8 miss held", {48'd0, miss_addr}, {48'd0, 16'hBEEF});
      check("R8 miss blocks", {63'd0, req_ready}, 64'd0);
    end
    miss_ready = 1;
    @(posedge clk);

    // Random stream against the reference model.
    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] a;
      int op;
      a = AW'((($urandom % 4) << 8) | ($urandom % 16));
      op = $urandom % 4;
      if (op == 0) do_fill(a, 3'($urandom % 5), 16'($urandom));
      else if (op == 1 && ($urandom % 3) == 0) do_inv(a[15:2]);
      else do_look(a);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule